// File: doc/BRIEF.md
# Block-Refill Memory Timing Model

This block stands in for the memory below a cache during block refills. A requester asks for one four-word block by block index. The block walks an address phase, one or more array-access phases and one or more transfer phases. It then returns the words on a lane-per-word data bus, with a per-lane valid mask. The phases follow one of three memory organizations chosen per request, so the same request port can show the refill penalty of a serial narrow memory, a banked memory, or a wide memory.

Storage is split into one bank per word offset. Bank k holds the word at offset k of every block. At reset every stored word is loaded with its own word address (block index times four plus offset), so any returned data can be predicted. After each block the block publishes the number of busy cycles that block took, so the miss penalty can be read at the ports.

Busy cycles are numbered from 1. Cycle 1 is the cycle after the clock edge that accepts the request.

Top module: `blkfill_mem`

## Requirements
- R1: After reset, req_ready is 1, rd_valid is 0, rd_done is 0 and lat_cycles is 0.
- R2: A request is accepted at a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the block completes. Requests presented while req_ready is 0 have no effect on the running block and do not start another.
- R3: req_mode selects the organization: 2'b00 one-word-wide, 2'b01 four-bank interleaved, 2'b10 four-word-wide. 2'b11 behaves as one-word-wide. The mode is sampled only at the accepting edge, so later changes do not alter a running block.
- R4: One-word-wide. After one address cycle, each word in turn takes a 15-cycle access followed by a 1-cycle transfer. Word k appears in busy cycle 16*(k+1)+1. The block takes 65 busy cycles.
- R5: Interleaved. After one address cycle, all banks access together for 15 cycles. The words then appear one per cycle in ascending offset order, offset k in busy cycle 17+k. The block takes 20 busy cycles.
- R6: Wide. After one address cycle and one 15-cycle access, all four words appear in a single beat in busy cycle 17, with rd_wmask = 4'b1111. The block takes 17 busy cycles.
- R7: During a beat, lane k (rd_data bits 32k+31 down to 32k) carries block_index*4+k when rd_wmask bit k is 1. A lane whose mask bit is 0 carries 0, and all lanes are 0 when no beat is present.
- R8: rd_done is 1 only in the cycle of the final beat of a block, together with rd_valid. req_ready is 1 again in the following cycle.
- R9: From the cycle after rd_done, lat_cycles equals the busy-cycle count of the block just completed (65, 20 or 17), and holds that value until the next block completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Block read request |
| req_ready | output | 1 | Idle and able to accept a request |
| req_addr | input | ADDR_W (4) | Block index |
| req_mode | input | 2 | Memory organization for this request |
| rd_valid | output | 1 | A beat of data is present |
| rd_wmask | output | NWORDS (4) | Lanes carrying a word in this beat |
| rd_data | output | NWORDS*DATA_W (128) | Word lanes, lane k at bits k*DATA_W upward |
| rd_done | output | 1 | Final beat of the block |
| lat_cycles | output | LAT_W (8) | Busy cycles of the last completed block |

## Verification
Several properties are checked on every cycle:
- Lane data against the latched block index, and zero lanes outside the mask.
- Ascending, back-to-back beats in interleaved mode.
- The single full-mask beat in wide mode.
- The return of ready after done, and the latency value against the latched organization.

Only the bench scenarios can show the following:
- The absolute placement of each beat within the busy window.
- That a request or mode change during a busy block leaves that block untouched and starts nothing afterwards.
- That the reserved mode code falls back to serial timing.

The bench sweeps every mode over every block index to cover these.

// File: rtl/blkfill_pkg.sv
package blkfill_pkg;

  typedef enum logic [1:0] {
    ORG_NARROW = 2'b00,
    ORG_BANKED = 2'b01,
    ORG_WIDE   = 2'b10,
    ORG_RSVD   = 2'b11
  } org_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_ACC  = 2'b10,
    PH_XFER = 2'b11
  } phase_e;

endpackage

// File: rtl/blkfill_seq.sv
module blkfill_seq
  import blkfill_pkg::*;
#(
  parameter int NWORDS   = 4,
  parameter int ADDR_W   = 4,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 15,
  parameter int XFER_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_mode,
  output logic              req_ready,
  output logic              accept,
  output logic              busy,
  output logic [ADDR_W-1:0] blk_q,
  output org_e              org_q,
  output logic [NWORDS-1:0] cap_mask,
  output logic              beat_valid,
  output logic [NWORDS-1:0] beat_mask,
  output logic              beat_last
);

  localparam int IDX_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int CNT_MAX = (ACC_CYC > ADDR_CYC) ?
                           ((ACC_CYC > XFER_CYC) ? ACC_CYC : XFER_CYC) :
                           ((ADDR_CYC > XFER_CYC) ? ADDR_CYC : XFER_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [NWORDS-1:0] ALL_LANES = {NWORDS{1'b1}};

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  org_e              org_d;
  logic [ADDR_W-1:0] blk_d;
  logic              ctx_en;
  logic              last_word;
  logic [NWORDS-1:0] cur_lane;

  assign req_ready = (phase_q == PH_IDLE);
  assign busy      = ~req_ready;
  assign accept    = req_ready & req_valid;
  assign ctx_en    = accept;
  assign last_word = (widx_q == IDX_W'(NWORDS - 1));
  assign cur_lane  = NWORDS'(1) << widx_q;

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    widx_d     = widx_q;
    org_d      = org_q;
    blk_d      = blk_q;
    cap_mask   = '0;
    beat_valid = 1'b0;
    beat_mask  = '0;
    beat_last  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          phase_d = PH_ADDR;
          cnt_d   = CNT_W'(ADDR_CYC - 1);
          widx_d  = '0;
          org_d   = (req_mode == ORG_RSVD) ? ORG_NARROW : org_e'(req_mode);
          blk_d   = req_addr;
        end
      end
      PH_ADDR: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACC;
          cnt_d   = CNT_W'(ACC_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACC: begin
        if (cnt_q == '0) begin
          cap_mask = (org_q == ORG_NARROW) ? cur_lane : ALL_LANES;
          phase_d  = PH_XFER;
          cnt_d    = CNT_W'(XFER_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_XFER: begin
        if (cnt_q == '0) begin
          beat_valid = 1'b1;
          beat_mask  = (org_q == ORG_WIDE) ? ALL_LANES : cur_lane;
          beat_last  = (org_q == ORG_WIDE) || last_word;
          if (beat_last) begin
            phase_d = PH_IDLE;
          end else begin
            widx_d = IDX_W'(widx_q + 1'b1);
            if (org_q == ORG_NARROW) begin
              phase_d = PH_ACC;
              cnt_d   = CNT_W'(ACC_CYC - 1);
            end else begin
              phase_d = PH_XFER;
              cnt_d   = CNT_W'(XFER_CYC - 1);
            end
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      widx_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      widx_q  <= widx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      org_q <= ORG_NARROW;
      blk_q <= '0;
    end else if (ctx_en) begin
      org_q <= org_d;
      blk_q <= blk_d;
    end
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_org_stable_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(org_q) && $stable(blk_q));

  a_r8_last_only_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

endmodule

// File: rtl/blkfill_bank.sv
module blkfill_bank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int NWORDS = 4,
  parameter int LANE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] blk,
  input  logic              cap_en,
  output logic [DATA_W-1:0] hold_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] hold_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < DEPTH; b++) begin
        mem_q[b] <= DATA_W'(b * NWORDS + LANE);
      end
    end
  end

  always_comb begin
    hold_d = cap_en ? mem_q[blk] : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (cap_en) begin
      hold_q <= hold_d;
    end
  end

  a_r7_capture_matches_address: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> hold_q == DATA_W'($past(blk) * NWORDS + LANE));

endmodule

// File: rtl/blkfill_meter.sv
module blkfill_meter #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic             fin,
  output logic [LAT_W-1:0] lat_q
);

  logic [LAT_W-1:0] run_q, run_d, lat_d;
  logic             run_en, lat_en;

  assign run_en = start | busy;
  assign lat_en = fin;

  always_comb begin
    run_d = start ? '0 : run_q + 1'b1;
    lat_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (lat_en) begin
      lat_q <= lat_d;
    end
  end

  a_r9_lat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fin) |-> $stable(lat_q));

endmodule

// File: rtl/blkfill_mem.sv
module blkfill_mem
  import blkfill_pkg::*;
#(
  parameter int NWORDS   = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 15,
  parameter int XFER_CYC = 1,
  parameter int LAT_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_mode,
  output logic                     rd_valid,
  output logic [NWORDS-1:0]        rd_wmask,
  output logic [NWORDS*DATA_W-1:0] rd_data,
  output logic                     rd_done,
  output logic [LAT_W-1:0]         lat_cycles
);

  localparam int LAT_NARROW = ADDR_CYC + NWORDS * (ACC_CYC + XFER_CYC);
  localparam int LAT_BANKED = ADDR_CYC + ACC_CYC + NWORDS * XFER_CYC;
  localparam int LAT_WIDE   = ADDR_CYC + ACC_CYC + XFER_CYC;

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              accept, busy;
  logic [ADDR_W-1:0] blk_q;
  org_e              org_q;
  logic [NWORDS-1:0] cap_mask, beat_mask;
  logic              beat_valid, beat_last;
  logic [LAT_W-1:0]  exp_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  blkfill_seq #(
    .NWORDS(NWORDS), .ADDR_W(ADDR_W), .ADDR_CYC(ADDR_CYC),
    .ACC_CYC(ACC_CYC), .XFER_CYC(XFER_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_i),
    .req_valid(req_valid), .req_addr(req_addr), .req_mode(req_mode),
    .req_ready(req_ready), .accept(accept), .busy(busy),
    .blk_q(blk_q), .org_q(org_q), .cap_mask(cap_mask),
    .beat_valid(beat_valid), .beat_mask(beat_mask), .beat_last(beat_last)
  );

  for (genvar k = 0; k < NWORDS; k++) begin : g_lane
    logic [DATA_W-1:0] hold;
    blkfill_bank #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NWORDS(NWORDS), .LANE(k)
    ) u_bank (
      .clk(clk), .rst_n(rst_n_i), .blk(blk_q),
      .cap_en(cap_mask[k]), .hold_q(hold)
    );
    assign rd_data[k*DATA_W +: DATA_W] = beat_mask[k] ? hold : '0;

    a_r7_lane_data: assert property (@(posedge clk) disable iff (!rst_n_i)
      (rd_valid && rd_wmask[k]) |-> rd_data[k*DATA_W +: DATA_W] == DATA_W'(blk_q * NWORDS + k));
    a_r7_lane_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
      !rd_wmask[k] |-> rd_data[k*DATA_W +: DATA_W] == '0);
  end

  blkfill_meter #(.LAT_W(LAT_W)) u_meter (
    .clk(clk), .rst_n(rst_n_i), .start(accept), .busy(busy),
    .fin(beat_last), .lat_q(lat_cycles)
  );

  assign rd_valid = beat_valid;
  assign rd_wmask = beat_mask;
  assign rd_done  = beat_last;

  always_comb begin
    case (org_q)
      ORG_BANKED: exp_lat = LAT_W'(LAT_BANKED);
      ORG_WIDE:   exp_lat = LAT_W'(LAT_WIDE);
      default:    exp_lat = LAT_W'(LAT_NARROW);
    endcase
  end

  a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n_i)
    rd_done |=> req_ready);

  a_r8_done_with_beat: assert property (@(posedge clk) disable iff (!rst_n_i)
    rd_done |-> rd_valid);

  a_r9_latency_value: assert property (@(posedge clk) disable iff (!rst_n_i)
    rd_done |=> lat_cycles == $past(exp_lat));

  a_r5_banked_ascending: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_valid && org_q == ORG_BANKED && !rd_wmask[0]) |->
      $past(rd_valid) && rd_wmask == ($past(rd_wmask) << 1));

  a_r6_wide_single_beat: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_valid && org_q == ORG_WIDE) |-> (&rd_wmask) && rd_done);

  a_r4_narrow_one_lane: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_valid && org_q == ORG_NARROW) |-> $onehot(rd_wmask));

endmodule

// File: tb/tb_blkfill_mem.sv
module tb_blkfill_mem;

  localparam int NW = 4;
  localparam int DW = 32;
  localparam int AW = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [AW-1:0]   req_addr;
  logic [1:0]      req_mode;
  logic            rd_valid;
  logic [NW-1:0]   rd_wmask;
  logic [NW*DW-1:0] rd_data;
  logic            rd_done;
  logic [7:0]      lat_cycles;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  blkfill_mem dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mode(req_mode), .rd_valid(rd_valid),
    .rd_wmask(rd_wmask), .rd_data(rd_data), .rd_done(rd_done),
    .lat_cycles(lat_cycles)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic run_req(input int mode, input int addr, input bit poke);
    int eff, total, busy_n, beats, exp_c;
    bit fin;
    logic [NW-1:0] exp_m;
    eff   = (mode == 3) ? 0 : mode;
    total = (eff == 0) ? 65 : (eff == 1) ? 20 : 17;
    @(negedge clk);
    req_valid = 1'b1;
    req_mode  = 2'(mode);
    req_addr  = AW'(addr);
    @(negedge clk);
    if (poke) begin
      req_mode = 2'(eff == 2 ? 0 : 2);
      req_addr = ~AW'(addr);
    end else begin
      req_valid = 1'b0;
    end
    busy_n = 0;
    beats  = 0;
    fin    = 1'b0;
    while (!fin && busy_n < 200) begin
      if (!req_ready) busy_n++;
      if (rd_valid) begin
        if (eff == 0) begin
          exp_c = 1 + 16 * (beats + 1);
          exp_m = NW'(1) << beats;
          chk(busy_n == exp_c, "R4", "beat cycle", busy_n, exp_c);
        end else if (eff == 1) begin
          exp_c = 17 + beats;
          exp_m = NW'(1) << beats;
          chk(busy_n == exp_c, "R5", "beat cycle", busy_n, exp_c);
        end else begin
          exp_c = 17;
          exp_m = '1;
          chk(busy_n == exp_c, "R6", "beat cycle", busy_n, exp_c);
        end
        chk(rd_wmask == exp_m, "R3", "beat mask", rd_wmask, exp_m);
        for (int k = 0; k < NW; k++) begin
          logic [DW-1:0] ev;
          ev = exp_m[k] ? DW'(addr * NW + k) : '0;
          chk(rd_data[k*DW +: DW] == ev, "R7", "lane data", rd_data[k*DW +: DW], ev);
        end
        beats++;
      end
      if (rd_done) fin = 1'b1;
      else @(negedge clk);
    end
    chk(busy_n == total, "R2", "busy cycles", busy_n, total);
    chk(beats == ((eff == 2) ? 1 : NW), "R8", "beats before done", beats,
        (eff == 2) ? 1 : NW);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b1, "R8", "ready after done", req_ready, 1);
    chk(lat_cycles == 8'(total), "R9", "lat_cycles", lat_cycles, total);
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(rd_valid == 1'b0 && req_ready == 1'b1, "R2", "no stray block",
            {rd_valid, req_ready}, 1);
        chk(lat_cycles == 8'(total), "R9", "lat held", lat_cycles, total);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_mode  = 2'b00;
    req_addr  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready at reset", req_ready, 1);
    chk(rd_valid == 1'b0, "R1", "valid at reset", rd_valid, 0);
    chk(rd_done == 1'b0, "R1", "done at reset", rd_done, 0);
    chk(lat_cycles == 8'd0, "R1", "lat at reset", lat_cycles, 0);
    chk(rd_data == '0, "R7", "idle lanes", 0, 0);
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < (1 << AW); a++) begin
        run_req(m, a, (a % 2) == 1);
      end
    end
    run_req(2, 5, 1'b0);
    run_req(0, 15, 1'b1);
    run_req(1, 0, 1'b1);
    summary();
    $finish;
  end

endmodule